// File: doc/BRIEF.md
# Long-Press Push-Button Reset Controller

This controller turns push-button activity into a hardware reset pulse only when the buttons are held down for a sustained time. Brief taps do nothing, so software can use the same buttons as an ordinary interrupt source. Two active-low button inputs must be held low together. A two-bit select picks the required hold time of 2, 6 or 10 seconds. Once the hold qualifies, the block drives a reset pulse of fixed length. After that pulse, both buttons must be released before another long press can count.

Two other paths force the reset at once, with no hold time. The first is an edge-triggered instant-reset request. After it has produced a reset, its falling edge opens a debounce window in which new rising edges are ignored. The second is a supply-undervoltage flag, which holds the reset for as long as it is high and for one pulse length after it clears. Every duration is a count of clock cycles of a slow timebase. Parameters convert seconds and milliseconds into cycles, and a parameter sets the polarity of the reset output.

Top module: `lpr_ctrl`

## Requirements
- R1: A long press needs both button inputs low at the same time. Holding only one button low, for any length of time, never asserts the reset output.
- R2: The select code sets the hold limit N in seconds: 00 gives 2, 01 gives 6, 10 gives 10, and 11 is treated as 10. N is that value multiplied by TICKS_PER_SEC. A joint press held for more than N clock cycles fires a reset. The output becomes active on the (N+3)th rising clock edge after the press is applied.
- R3: A joint press lasting N cycles or fewer produces no reset activity. Releasing either button before the limit abandons the count.
- R4: A reset from a long press or from the instant request is active for exactly PULSE_TICKS cycles. PULSE_TICKS is PULSE_MS milliseconds rounded up to whole ticks.
- R5: After a long-press reset, no further reset occurs while either button is still held. Once both buttons are released, a new long press qualifies again.
- R6: A rising edge on the instant request makes the output active on the third rising clock edge after it is applied, with no hold delay. This also holds in the middle of a long-press count.
- R7: After an accepted instant request, its falling edge starts a lockout of DEB_TICKS cycles, which is DEBOUNCE_MS rounded up to whole ticks. Rising edges during the lockout produce no reset. Rising edges after it are accepted.
- R8: While the undervoltage flag is high, the output is active. It turns active on the third edge after the flag rises. After the flag falls, the output stays active for PULSE_TICKS more cycles and turns inactive on edge PULSE_TICKS+2.
- R9: With ACTIVE_HIGH=0 the output is low when active. With ACTIVE_HIGH=1 it is the exact inverse on every cycle.
- R10: While rst is high, and on the first edge it is applied (even in the middle of a pulse), the output goes to its inactive level. All timers return to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow timebase clock; one cycle is one tick |
| rst | input | 1 | Synchronous active-high power-on reset |
| btn_a_n | input | 1 | First push-button, active low, asynchronous |
| btn_b_n | input | 1 | Second push-button, active low, asynchronous |
| dly_sel | input | 2 | Hold-time select code (00/01/10/11), static |
| inst_req | input | 1 | Instant reset request, acts on its rising edge |
| uv_flag | input | 1 | Supply undervoltage flag, active high |
| rst_out | output | 1 | Reset output; polarity set by ACTIVE_HIGH |

## Verification
Joint presses are applied with every select code at exactly N cycles and at N+1 cycles. Failing at N while firing at N+1 pins each code's limit to the right count, and code 11 shows that it shares the 10-second limit. Other presses use a single held button, a very short tap, and a press held long past the pulse. These show that the block needs both buttons, ignores taps, and does not retrigger until release. The instant request is raised while idle, in the middle of a count, inside its lockout, and after it. The undervoltage flag is raised, held and dropped so that the exact trailing stretch can be measured. A second instance with the opposite polarity is compared against the first on every cycle.

// File: rtl/lpr_pkg.sv
package lpr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_PULSE = 2'd2,
        ST_HOLD  = 2'd3
    } lpr_state_e;

    // Synchronized view of the asynchronous pins
    typedef struct packed {
        logic       a_n;
        logic       b_n;
        logic [1:0] sel;
        logic       inst;
        logic       uv;
    } lpr_pins_s;

    localparam lpr_pins_s PINS_IDLE = '{a_n: 1'b1, b_n: 1'b1, sel: 2'b00, inst: 1'b0, uv: 1'b0};

    // Hold limit in seconds for a select code; 11 shares the longest setting
    function automatic int unsigned hold_secs(input logic [1:0] code);
        case (code)
            2'b00:   return 2;
            2'b01:   return 6;
            default: return 10;
        endcase
    endfunction

    // Milliseconds to ticks, rounded up so durations are minimums
    function automatic int unsigned ms_to_ticks(input int unsigned ms, input int unsigned tps);
        return (ms * tps + 999) / 1000;
    endfunction

endpackage

// File: rtl/lpr_sync.sv
module lpr_sync #(
    parameter int          W    = 1,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= INIT;
            q      <= INIT;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/lpr_inst_gate.sv
module lpr_inst_gate #(
    parameter int DEB_TICKS = 5,
    localparam int DW       = $clog2(DEB_TICKS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic inst_s,
    output logic trig
);
    logic          prev;
    logic          armed;
    logic [DW-1:0] lock;
    logic          rise;
    logic          fall;

    assign rise = inst_s & ~prev;
    assign fall = ~inst_s & prev;
    assign trig = rise & (lock == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev  <= 1'b0;
            armed <= 1'b0;
            lock  <= '0;
        end else begin
            prev <= inst_s;
            if (trig)
                armed <= 1'b1;
            if (fall && armed) begin
                lock  <= DW'(DEB_TICKS);
                armed <= 1'b0;
            end else if (lock != '0) begin
                lock <= lock - DW'(1);
            end
        end
    end

    // R7
    lockout_load_chk: assert property (@(posedge clk) disable iff (rst)
        (fall && armed) |=> (lock == DW'(DEB_TICKS)) && !trig);

    // R6
    single_trig_chk: assert property (@(posedge clk) disable iff (rst)
        trig |=> !trig);
endmodule

// File: rtl/lpr_fsm.sv
module lpr_fsm
    import lpr_pkg::*;
#(
    parameter int TICKS_PER_SEC = 1000,
    parameter int PULSE_TICKS   = 210,
    localparam int CW           = $clog2(10 * TICKS_PER_SEC + PULSE_TICKS + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       both_held,
    input  logic       both_free,
    input  logic [1:0] sel,
    input  logic       inst_trig,
    input  logic       uv,
    output logic       pulse_on
);
    lpr_state_e    state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;
    logic [CW-1:0] lim;
    logic          force_rst;

    assign lim       = CW'(hold_secs(sel) * TICKS_PER_SEC);
    assign force_rst = uv | inst_trig;

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        case (state)
            ST_IDLE: begin
                if (both_held) begin
                    state_nx = ST_SETUP;
                    cnt_nx   = '0;
                end
            end
            ST_SETUP: begin
                if (!both_held) begin
                    state_nx = ST_IDLE;
                    cnt_nx   = '0;
                end else if (cnt == lim - CW'(1)) begin
                    state_nx = ST_PULSE;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + CW'(1);
                end
            end
            ST_PULSE: begin
                if (cnt == CW'(PULSE_TICKS - 1)) begin
                    state_nx = ST_HOLD;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + CW'(1);
                end
            end
            ST_HOLD: begin
                if (both_free)
                    state_nx = ST_IDLE;
            end
            default: begin
                state_nx = ST_IDLE;
                cnt_nx   = '0;
            end
        endcase
        if (force_rst) begin
            state_nx = ST_PULSE;
            cnt_nx   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    assign pulse_on = (state == ST_PULSE);

    // R2
    hold_limit_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PULSE && $past(state) == ST_SETUP && !$past(force_rst))
            |-> ($past(cnt) == $past(lim) - CW'(1)));

    // R3
    abort_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SETUP && !both_held && !force_rst) |=> (state == ST_IDLE));

    // R4
    pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PULSE && cnt != CW'(PULSE_TICKS - 1) && !force_rst) |=> (state == ST_PULSE));

    // R5
    hold_release_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && !both_free && !force_rst) |=> (state == ST_HOLD));

    // R8
    uv_hold_chk: assert property (@(posedge clk) disable iff (rst)
        uv |=> (state == ST_PULSE && cnt == '0));
endmodule

// File: rtl/lpr_ctrl.sv
module lpr_ctrl
    import lpr_pkg::*;
#(
    parameter int TICKS_PER_SEC = 1000,
    parameter int PULSE_MS      = 210,
    parameter int DEBOUNCE_MS   = 240,
    parameter bit ACTIVE_HIGH   = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       btn_a_n,
    input  logic       btn_b_n,
    input  logic [1:0] dly_sel,
    input  logic       inst_req,
    input  logic       uv_flag,
    output logic       rst_out
);
    localparam int PULSE_TICKS = int'(ms_to_ticks(PULSE_MS, TICKS_PER_SEC));
    localparam int DEB_TICKS   = int'(ms_to_ticks(DEBOUNCE_MS, TICKS_PER_SEC));
    localparam int PIN_W       = $bits(lpr_pins_s);

    lpr_pins_s pins_raw, pins_s;
    logic      inst_trig;
    logic      pulse_on;

    assign pins_raw = '{a_n: btn_a_n, b_n: btn_b_n, sel: dly_sel, inst: inst_req, uv: uv_flag};

    lpr_sync #(.W(PIN_W), .INIT(PINS_IDLE)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw),
        .q   (pins_s)
    );

    lpr_inst_gate #(.DEB_TICKS(DEB_TICKS)) u_inst (
        .clk    (clk),
        .rst    (rst),
        .inst_s (pins_s.inst),
        .trig   (inst_trig)
    );

    lpr_fsm #(.TICKS_PER_SEC(TICKS_PER_SEC), .PULSE_TICKS(PULSE_TICKS)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .both_held (~pins_s.a_n & ~pins_s.b_n),
        .both_free (pins_s.a_n & pins_s.b_n),
        .sel       (pins_s.sel),
        .inst_trig (inst_trig),
        .uv        (pins_s.uv),
        .pulse_on  (pulse_on)
    );

    generate
        if (ACTIVE_HIGH) begin : g_pol_hi
            assign rst_out = pulse_on;
        end else begin : g_pol_lo
            assign rst_out = ~pulse_on;
        end
    endgenerate

    // R1
    one_button_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(pulse_on) && !$past(pins_s.uv) && !$past(inst_trig))
            |-> ($past(pins_s.a_n) == 1'b0 && $past(pins_s.b_n) == 1'b0));
endmodule

// File: tb/tb_lpr_ctrl.sv
module tb_lpr_ctrl;
    localparam int PERIOD = 10;
    localparam int TPS    = 20;
    localparam int PULSE  = 4;   // 200 ms at 20 ticks/s
    localparam int DEB    = 5;   // 240 ms rounded up
    localparam int NV     = 9;

    // stimulus table: select code, cycles held, fire expected
    localparam logic [1:0] V_SEL  [NV] = '{2'b00, 2'b00, 2'b01, 2'b01, 2'b10, 2'b10, 2'b11, 2'b11, 2'b00};
    localparam int         V_HOLD [NV] = '{40, 41, 120, 121, 200, 201, 200, 201, 3};
    localparam bit         V_FIRE [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

    logic       clk = 1'b0;
    logic       rst;
    logic       btn_a_n, btn_b_n, inst_req, uv_flag;
    logic [1:0] dly_sel;
    logic       rst_out, rst_out_h;

    int n_tests = 0;
    int n_fail  = 0;
    int act_cnt = 0;
    int pol_err = 0;
    int base;

    always #(PERIOD / 2) clk = ~clk;

    lpr_ctrl #(.TICKS_PER_SEC(TPS), .PULSE_MS(200), .DEBOUNCE_MS(240), .ACTIVE_HIGH(1'b0)) dut (
        .clk(clk), .rst(rst), .btn_a_n(btn_a_n), .btn_b_n(btn_b_n), .dly_sel(dly_sel),
        .inst_req(inst_req), .uv_flag(uv_flag), .rst_out(rst_out));

    lpr_ctrl #(.TICKS_PER_SEC(TPS), .PULSE_MS(200), .DEBOUNCE_MS(240), .ACTIVE_HIGH(1'b1)) dut_hi (
        .clk(clk), .rst(rst), .btn_a_n(btn_a_n), .btn_b_n(btn_b_n), .dly_sel(dly_sel),
        .inst_req(inst_req), .uv_flag(uv_flag), .rst_out(rst_out_h));

    always @(posedge clk) begin
        if (!rst && rst_out == 1'b0)
            act_cnt <= act_cnt + 1;
        if (rst_out_h !== ~rst_out)
            pol_err <= pol_err + 1;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic press(input logic [1:0] sel, input int hold, input bit fire, input string tag);
        dly_sel = sel;
        ticks(4);
        base = act_cnt;
        btn_a_n = 1'b0;
        btn_b_n = 1'b0;
        ticks(hold);
        btn_a_n = 1'b1;
        btn_b_n = 1'b1;
        ticks(PULSE + 12);
        check((act_cnt - base) == (fire ? PULSE : 0), tag, act_cnt - base, fire ? PULSE : 0);
        check(rst_out == 1'b1, {tag, " idle after"}, rst_out, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; btn_a_n = 1'b1; btn_b_n = 1'b1; dly_sel = 2'b00; inst_req = 1'b0; uv_flag = 1'b0;
        ticks(3);
        // R10 and R9 reset levels
        check(rst_out == 1'b1, "R10 reset level", rst_out, 1);
        check(rst_out_h == 1'b0, "R9 high polarity reset level", rst_out_h, 0);
        rst = 1'b0;
        ticks(3);
        check(rst_out == 1'b1, "R10 idle after reset", rst_out, 1);

        // R2 R3 table walk
        for (int i = 0; i < NV; i++)
            press(V_SEL[i], V_HOLD[i], V_FIRE[i], V_FIRE[i] ? "R2 long press" : "R3 short press");

        // R2 exact onset edge for code 00
        dly_sel = 2'b00;
        ticks(4);
        btn_a_n = 1'b0; btn_b_n = 1'b0;
        ticks(2 * TPS + 2);
        check(rst_out == 1'b1, "R2 not yet at N+2", rst_out, 1);
        ticks(1);
        check(rst_out == 1'b0, "R2 active at N+3", rst_out, 0);
        ticks(PULSE - 1);
        check(rst_out == 1'b0, "R4 last pulse cycle", rst_out, 0);
        ticks(1);
        check(rst_out == 1'b1, "R4 pulse ended", rst_out, 1);
        btn_a_n = 1'b1; btn_b_n = 1'b1;
        ticks(10);

        // R5 held long past the pulse, then re-press
        base = act_cnt;
        btn_a_n = 1'b0; btn_b_n = 1'b0;
        ticks(2 * TPS + 1 + PULSE + 80);
        check((act_cnt - base) == PULSE, "R5 no retrigger while held", act_cnt - base, PULSE);
        btn_a_n = 1'b1; btn_b_n = 1'b1;
        ticks(8);
        press(2'b00, 2 * TPS + 1, 1'b1, "R5 re-press after release");

        // R1 single button
        base = act_cnt;
        btn_a_n = 1'b0;
        ticks(300);
        btn_a_n = 1'b1;
        btn_b_n = 1'b0;
        ticks(300);
        btn_b_n = 1'b1;
        ticks(8);
        check((act_cnt - base) == 0, "R1 one button only", act_cnt - base, 0);

        // R6 instant request from idle
        base = act_cnt;
        inst_req = 1'b1;
        ticks(2);
        check(rst_out == 1'b1, "R6 not before third edge", rst_out, 1);
        ticks(1);
        check(rst_out == 1'b0, "R6 active at third edge", rst_out, 0);
        ticks(10);
        inst_req = 1'b0;
        ticks(1);
        inst_req = 1'b1;          // inside the lockout
        ticks(20);
        check((act_cnt - base) == PULSE, "R7 edge in lockout ignored", act_cnt - base, PULSE);
        inst_req = 1'b0;
        ticks(DEB + 15);
        base = act_cnt;
        inst_req = 1'b1;
        ticks(20);
        check((act_cnt - base) == PULSE, "R7 edge after lockout accepted", act_cnt - base, PULSE);
        inst_req = 1'b0;
        ticks(DEB + 15);

        // R6 instant request during a long-press count
        dly_sel = 2'b01;
        ticks(4);
        base = act_cnt;
        btn_a_n = 1'b0; btn_b_n = 1'b0;
        ticks(20);
        inst_req = 1'b1;
        ticks(3);
        check(rst_out == 1'b0, "R6 instant during count", rst_out, 0);
        ticks(200);
        check((act_cnt - base) == PULSE, "R6 one pulse then held", act_cnt - base, PULSE);
        btn_a_n = 1'b1; btn_b_n = 1'b1;
        inst_req = 1'b0;
        ticks(DEB + 15);

        // R8 undervoltage
        uv_flag = 1'b1;
        ticks(2);
        check(rst_out == 1'b1, "R8 not before third edge", rst_out, 1);
        ticks(1);
        check(rst_out == 1'b0, "R8 active at third edge", rst_out, 0);
        ticks(30);
        check(rst_out == 1'b0, "R8 held while flag high", rst_out, 0);
        uv_flag = 1'b0;
        ticks(PULSE + 1);
        check(rst_out == 1'b0, "R8 trailing stretch", rst_out, 0);
        ticks(1);
        check(rst_out == 1'b1, "R8 released after stretch", rst_out, 1);
        ticks(5);

        // R10 reset in the middle of a pulse
        uv_flag = 1'b1;
        ticks(5);
        uv_flag = 1'b0;
        rst = 1'b1;
        ticks(1);
        check(rst_out == 1'b1, "R10 reset cuts pulse", rst_out, 1);
        rst = 1'b0;
        ticks(10);
        check(rst_out == 1'b1, "R10 stays idle", rst_out, 1);

        // R9 inverse polarity throughout
        check(pol_err == 0, "R9 polarity mismatch cycles", pol_err, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule